// File: doc/BRIEF.md
# Carry-Status Prefix Tree

This block computes every carry prefix of a chain of carry statuses in a single combinational pass. Each position supplies a two-bit status: kill, propagate or generate. The block returns one carry bit per position. Output i is the carry that results from folding statuses 0 through i in order, with lower positions first. Position 0 is the seed, normally the carry-in of an adder. Positions 1 to N are the per-bit statuses of the operand pairs.

The network is a complete binary tree over positions 1 to N, where N is a power of two. The seed enters at the root. Each internal node has two composition elements. The upward element merges the spans of its two children and passes the result toward the root. The downward element receives the prefix that ends just before the node's leftmost position. It passes that prefix unchanged to the left child, and passes it merged with the left child's span to the right child. A leaf receives the prefix ending just below its own position and drives the corresponding output. One extra element at the root merges the seed with the span of the whole tree to form output N. The tree therefore holds 2N-1 elements, and its depth is about twice log2 N.

The block has no clock, no reset and no states; it evaluates continuously. Surrounding adders read output i as the carry into bit i.

Top module: `ppx_carry_tree`

## Requirements
- R1: Output bit 0 is 1 when the seed status is generate (11) and 0 when it is kill (00).
- R2: For every i from 0 to N, output bit i equals the carry obtained by folding statuses 0..i from low to high. In that fold, a kill or generate status replaces the running value, and a propagate status leaves it unchanged.
- R3: When status i (i >= 1) is generate (11), output bit i is 1, whatever the lower statuses are.
- R4: When status i (i >= 1) is kill (00), output bit i is 0, whatever the lower statuses are.
- R5: When status i (i >= 1) is propagate, output bit i equals output bit i-1.
- R6: The propagate codes 01 and 10 give identical outputs in every position.
- R7: When statuses 1..N are all propagate, every output, including the top output N formed at the root, equals the seed carry.
- R8: The seed status is kill or generate. Under that condition no prefix is ever propagate, so each output is a single bit with 1 for generate and 0 for kill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_st | input | 2*(N+1) | Carry statuses; status i in bits [2i+1:2i], 00 kill, 11 generate, 01/10 propagate; status 0 is the seed |
| y_pfx | output | N+1 | Prefix carries; bit i is 1 when the fold of statuses 0..i is generate |

## Verification
A wrong value inside the tree can be a bad span on the upward pass or a bad prefix on the downward pass. Either one appears on the outputs in the same evaluation, because the block holds no state. The fault shows on every output whose range includes the faulty span and that has no kill or generate status above it to mask the error. Because of this masking, the exposing patterns are long runs of propagate over a known seed, together with a single generate or kill placed at each position. An exhaustive sweep at four positions and a random sweep at sixteen cover the tree shapes and the root element.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

    typedef logic [1:0] cst_t;

    localparam cst_t CST_KILL = 2'b00;
    localparam cst_t CST_GEN  = 2'b11;

    function automatic logic cst_is_prop(input cst_t s);
        return s[1] ^ s[0];
    endfunction

    // lo covers lower positions, hi the adjacent higher ones
    function automatic cst_t cst_merge(input cst_t lo, input cst_t hi);
        return cst_is_prop(hi) ? lo : hi;
    endfunction

endpackage

// File: rtl/ppx_combine.sv
module ppx_combine
    import ppx_pkg::*;
(
    input  cst_t lo_st,
    input  cst_t hi_st,
    output cst_t res_st
);
    assign res_st = cst_merge(lo_st, hi_st);
endmodule

// File: rtl/ppx_subtree.sv
module ppx_subtree
    import ppx_pkg::*;
#(
    parameter int LEAVES = 8
) (
    input  logic [2*LEAVES-1:0] leaf_st,
    input  cst_t                before_st,
    output cst_t                span_st,
    output logic [2*LEAVES-1:0] pfx_st
);
    generate
        if (LEAVES == 1) begin : g_leaf
            assign span_st = leaf_st;
            assign pfx_st  = before_st;
        end else begin : g_node
            localparam int HALF = LEAVES / 2;
            cst_t left_span;
            cst_t right_span;
            cst_t right_before;

            ppx_subtree #(.LEAVES(HALF)) u_left (
                .leaf_st  (leaf_st[2*HALF-1:0]),
                .before_st(before_st),
                .span_st  (left_span),
                .pfx_st   (pfx_st[2*HALF-1:0])
            );

            ppx_subtree #(.LEAVES(HALF)) u_right (
                .leaf_st  (leaf_st[2*LEAVES-1:2*HALF]),
                .before_st(right_before),
                .span_st  (right_span),
                .pfx_st   (pfx_st[2*LEAVES-1:2*HALF])
            );

            // upward element
            ppx_combine u_up (
                .lo_st (left_span),
                .hi_st (right_span),
                .res_st(span_st)
            );

            // downward element
            ppx_combine u_down (
                .lo_st (before_st),
                .hi_st (left_span),
                .res_st(right_before)
            );
        end
    endgenerate
endmodule

// File: rtl/ppx_carry_tree.sv
module ppx_carry_tree
    import ppx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*(N+1)-1:0] x_st,
    output logic [N:0]         y_pfx
);
    localparam int VW = 2 * N;

    cst_t           seed_st;
    cst_t           tree_span;
    cst_t           top_st;
    logic [VW-1:0]  leaf_pfx;

    assign seed_st = x_st[1:0];

    ppx_subtree #(.LEAVES(N)) u_tree (
        .leaf_st  (x_st[2*(N+1)-1:2]),
        .before_st(seed_st),
        .span_st  (tree_span),
        .pfx_st   (leaf_pfx)
    );

    // extra root element
    ppx_combine u_root (
        .lo_st (seed_st),
        .hi_st (tree_span),
        .res_st(top_st)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_out
            assign y_pfx[gi] = leaf_pfx[2*gi+1];
        end
    endgenerate
    assign y_pfx[N] = top_st[1];

    // ---------------- assertions ----------------
    always_comb begin
        if (!$isunknown(x_st) && !cst_is_prop(seed_st)) begin
            assert_seed_carry_R1: assert (y_pfx[0] == seed_st[1])
                else $error("seed carry mismatch");
            assert_top_prefix_R8: assert (!cst_is_prop(top_st))
                else $error("root prefix is propagate");
        end
    end

    generate
        for (gi = 0; gi < N; gi++) begin : g_chk
            always_comb begin
                if (!$isunknown(x_st) && !cst_is_prop(seed_st)) begin
                    assert_leaf_prefix_R8: assert (!cst_is_prop(leaf_pfx[2*gi+:2]))
                        else $error("leaf prefix is propagate");
                    if (x_st[2*(gi+1)+:2] == CST_GEN)
                        assert_gen_forces_R3: assert (y_pfx[gi+1] == 1'b1)
                            else $error("generate not honoured");
                    if (x_st[2*(gi+1)+:2] == CST_KILL)
                        assert_kill_forces_R4: assert (y_pfx[gi+1] == 1'b0)
                            else $error("kill not honoured");
                    if (cst_is_prop(x_st[2*(gi+1)+:2]))
                        assert_prop_passes_R5: assert (y_pfx[gi+1] == y_pfx[gi])
                            else $error("propagate did not pass carry");
                end
            end
        end
    endgenerate
endmodule

// File: tb/tb_ppx_carry_tree.sv
module tb_ppx_carry_tree;

    localparam int N = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [2*(N+1)-1:0] xs8  = '0;
    logic [N:0]         ys8;
    logic [9:0]         xs4  = '0;
    logic [4:0]         ys4;
    logic [33:0]        xs16 = '0;
    logic [16:0]        ys16;

    ppx_carry_tree #(.N(N))  dut     (.x_st(xs8),  .y_pfx(ys8));
    ppx_carry_tree #(.N(4))  dut_n4  (.x_st(xs4),  .y_pfx(ys4));
    ppx_carry_tree #(.N(16)) dut_n16 (.x_st(xs16), .y_pfx(ys16));

    function automatic logic [16:0] ref_fold(input logic [33:0] xv, input int n);
        logic [16:0] r = '0;
        logic        acc = xv[1];
        r[0] = acc;
        for (int i = 1; i <= n; i++) begin
            if (xv[2*i+:2] == 2'b11) acc = 1'b1;
            else if (xv[2*i+:2] == 2'b00) acc = 1'b0;
            r[i] = acc;
        end
        return r;
    endfunction

    task automatic chk(input logic [16:0] act, input logic [16:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive8(input logic [2*(N+1)-1:0] v);
        @(posedge clk);
        xs8 = v;
        @(negedge clk);
    endtask

    // R2 at N=8 against the fold
    task automatic run8(input logic [2*(N+1)-1:0] v, input string req);
        drive8(v);
        chk({8'b0, ys8}, ref_fold({16'b0, v}, N), req);
    endtask

    task automatic t_all_kill();
        drive8('0);
        chk({8'b0, ys8}, 17'd0, "R4 all kill");
    endtask

    task automatic t_seed();
        drive8({{N{2'b01}}, 2'b11});
        chk({16'b0, ys8[0]}, 17'd1, "R1 seed generate");
        drive8({{N{2'b01}}, 2'b00});
        chk({16'b0, ys8[0]}, 17'd0, "R1 seed kill");
    endtask

    task automatic t_gen_force();
        for (int p = 1; p <= N; p++) begin
            logic [2*(N+1)-1:0] v = '0;
            v[2*p+:2] = 2'b11;
            drive8(v);
            chk({16'b0, ys8[p]}, 17'd1, "R3 generate forces one");
        end
    endtask

    task automatic t_kill_force();
        for (int p = 1; p <= N; p++) begin
            logic [2*(N+1)-1:0] v = {{N{2'b10}}, 2'b11};
            v[2*p+:2] = 2'b00;
            drive8(v);
            chk({16'b0, ys8[p]}, 17'd0, "R4 kill forces zero");
            chk({8'b0, ys8}, ref_fold({16'b0, v}, N), "R5 propagate after kill");
        end
    endtask

    task automatic t_prop_chain();
        drive8({{N{2'b01}}, 2'b11});
        chk({8'b0, ys8}, {8'b0, {(N+1){1'b1}}}, "R7 chain carries generate seed");
        drive8({{N{2'b10}}, 2'b00});
        chk({8'b0, ys8}, 17'd0, "R7 chain carries kill seed");
    endtask

    task automatic t_prop_codes();
        logic [2*(N+1)-1:0] va = 18'b01_11_01_00_01_01_11_01_11;
        logic [2*(N+1)-1:0] vb = 18'b10_11_10_00_10_10_11_10_11;
        logic [N:0] ya;
        drive8(va);
        ya = ys8;
        drive8(vb);
        chk({8'b0, ys8}, {8'b0, ya}, "R6 propagate codes match");
        chk({8'b0, ys8}, ref_fold({16'b0, vb}, N), "R2 mixed pattern");
    endtask

    task automatic t_directed8();
        run8(18'b00_11_01_01_00_10_11_01_00, "R2 pattern a");
        run8(18'b01_01_01_01_01_01_01_01_11, "R2 pattern b");
        run8(18'b11_00_11_00_11_00_11_00_11, "R2 pattern c");
        run8(18'b10_10_10_11_10_10_10_00_00, "R2 pattern d");
    endtask

    task automatic t_exhaustive4();
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 256; m++) begin
                logic [9:0] v;
                v = {m[7:0], (s == 1) ? 2'b11 : 2'b00};
                @(posedge clk);
                xs4 = v;
                @(negedge clk);
                chk({12'b0, ys4}, ref_fold({24'b0, v}, 4), "R2 exhaustive N=4");
            end
        end
    endtask

    task automatic t_random16();
        for (int k = 0; k < 2000; k++) begin
            logic [33:0] v;
            v[1:0] = ($urandom % 2 == 1) ? 2'b11 : 2'b00;
            for (int i = 1; i <= 16; i++) v[2*i+:2] = 2'($urandom % 4);
            @(posedge clk);
            xs16 = v;
            @(negedge clk);
            chk(ys16, ref_fold(v, 16), "R2 random N=16");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_all_kill();
        t_seed();
        t_gen_force();
        t_kill_force();
        t_prop_chain();
        t_prop_codes();
        t_directed8();
        t_exhaustive4();
        t_random16();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule